// File: doc/BRIEF.md
# Sequential Serial-EEPROM Block Reader

This block is a two-wire bus master that fetches a run of consecutive bytes from a serial EEPROM, for example the configuration memory of a memory module. A pulse on `go_i` starts one transaction at the byte address on `reg_addr_i`. The master first performs a dummy write that loads the word address into the memory. It then turns the bus around with a repeated start and reads sequentially. Each received byte leaves the block on `byte_o` with a one-cycle strobe.

SCL is driven push-pull from a divider of the system clock. One bus bit takes four quarter periods of `SCL_QDIV` system clocks each. SDA is open drain: `sda_oe_o` high pulls the line low, and the line level comes back on `sda_i`. The master acknowledges every data byte except the final one. On the final byte it leaves SDA released and then ends with a stop. If the slave fails to acknowledge any address byte, the master stops at once and raises an error flag. In every case a done pulse follows the stop.

Top module: `eeprom_seq_reader`

## Requirements
- R1: Out of reset and whenever no transaction runs, `scl_o` is 1, `sda_oe_o` is 0 and `busy_o`, `byte_vld_o`, `done_o` and `err_o` are 0.
- R2: A transaction opens with a start condition (SDA falls while SCL is high), followed by the byte 0xA0 (device address 1010000, write bit 0), MSB first, and then an acknowledge slot in which SDA is released and sampled.
- R3: The next byte sent is the value of `reg_addr_i` captured at `go_i`, followed by an acknowledge slot.
- R4: The master then issues a repeated start with no stop condition in between, sends 0xA1 (read bit 1) and samples the acknowledge.
- R5: Data bytes are assembled MSB first and presented on `byte_o` with a one-cycle `byte_vld_o` pulse, in memory order starting at the given address, with the address wrapping modulo 256.
- R6: The master drives SDA low (ACK) in the acknowledge slot of every data byte except the last. In the last slot it leaves SDA high (NACK), then generates exactly one stop condition (SDA rises while SCL is high).
- R7: A transaction delivers exactly `XFER_LEN` bytes (default 128).
- R8: If any of the three address bytes is not acknowledged (SDA high in its ninth slot), the master generates a stop, delivers no data bytes and sets `err_o`. `err_o` stays set until the next `go_i` clears it.
- R9: SDA changes while SCL is high only for start, repeated start and stop conditions. Every data and acknowledge bit changes SDA while SCL is low.
- R10: `done_o` pulses for exactly one cycle after the stop has completed, and `busy_o` is 0 in that cycle.
- R11: A `go_i` pulse that arrives while a transaction is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Start-transaction pulse, accepted only when idle |
| reg_addr_i | input | 8 | First byte address to read |
| sda_i | input | 1 | Level of the SDA line |
| scl_o | output | 1 | Serial clock |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | A transaction is in progress |
| byte_o | output | 8 | Last received data byte |
| byte_vld_o | output | 1 | One-cycle strobe for `byte_o` |
| done_o | output | 1 | One-cycle pulse after the closing stop |
| err_o | output | 1 | An address byte was not acknowledged |

## Verification
A behavioural EEPROM slave on the open-drain line serves contents computed from a per-transaction random seed. Transactions start at address 0x00, at 0xF0 (which crosses the 256-byte wrap) and at random addresses. Comparing every received byte against the seeded contents separates bit order, address loading and sequencing errors. Three runs have the slave refuse the write address, the word address and the read address in turn; these show that each address phase is checked separately and that the error path skips reading. A second `go_i` injected mid-transaction, and the count of SDA edges seen while SCL is high, show that stray start requests and glitches on the data line stay out.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PC_START,
        PC_RSTART,
        PC_STOP,
        PC_WRITE,
        PC_READ
    } pcmd_e;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_START,
        CS_DEVW,
        CS_REG,
        CS_RSTART,
        CS_DEVR,
        CS_READ,
        CS_STOP
    } cstate_e;

    // Line levels {scl, sda_pull_low} for one quarter of a bus slot.
    function automatic logic [1:0] line_of(input pcmd_e c, input logic [1:0] ph, input logic b);
        logic [1:0] r;
        case (c)
            PC_START: begin
                case (ph)
                    2'd0:    r = 2'b10;
                    2'd1:    r = 2'b11;
                    default: r = 2'b01;
                endcase
            end
            PC_RSTART: begin
                case (ph)
                    2'd0:    r = 2'b00;
                    2'd1:    r = 2'b10;
                    2'd2:    r = 2'b11;
                    default: r = 2'b01;
                endcase
            end
            PC_STOP: begin
                case (ph)
                    2'd0:    r = 2'b01;
                    2'd1:    r = 2'b11;
                    default: r = 2'b10;
                endcase
            end
            default: begin
                r[1] = (ph == 2'd1) || (ph == 2'd2);
                r[0] = (c == PC_WRITE) ? ~b : 1'b0;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/eeprom_rd_tick.sv
module eeprom_rd_tick #(
    parameter int QDIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q == CW'(QDIV - 1));
        cnt_d  = tick_o ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/eeprom_rd_phy.sv
module eeprom_rd_phy
    import eeprom_rd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_i,
    input  logic  cmd_vld_i,
    input  pcmd_e cmd_i,
    input  logic  bit_i,
    input  logic  sda_i,
    output logic  done_o,
    output logic  rx_o,
    output logic  scl_o,
    output logic  sda_oe_o,
    output logic  cond_o
);
    typedef struct packed {
        logic       busy;
        pcmd_e      cmd;
        logic [1:0] qph;
        logic       bitv;
        logic       rx;
        logic       done;
        logic       scl;
        logic       oe;
    } phy_t;

    phy_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy && cmd_vld_i) begin
            d.busy = 1'b1;
            d.cmd  = cmd_i;
            d.qph  = 2'd0;
            d.bitv = bit_i;
        end else if (q.busy && tick_i) begin
            {d.scl, d.oe} = line_of(q.cmd, q.qph, q.bitv);
            if (q.qph == 2'd2) d.rx = sda_i;
            d.qph = q.qph + 2'd1;
            if (q.qph == 2'd3) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, cmd: PC_STOP, qph: 2'd0, bitv: 1'b0,
                   rx: 1'b1, done: 1'b0, scl: 1'b1, oe: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign done_o   = q.done;
    assign rx_o     = q.rx;
    assign scl_o    = q.scl;
    assign sda_oe_o = q.oe;
    assign cond_o   = q.busy && ((q.cmd == PC_START) || (q.cmd == PC_RSTART) || (q.cmd == PC_STOP));
endmodule

// File: rtl/eeprom_rd_ctrl.sv
module eeprom_rd_ctrl
    import eeprom_rd_pkg::*;
#(
    parameter int         XFER_LEN = 128,
    parameter logic [6:0] DEV_ADDR = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [BYTE_W-1:0] reg_addr_i,
    input  logic              phy_done_i,
    input  logic              phy_rx_i,
    output logic              cmd_vld_o,
    output pcmd_e             cmd_o,
    output logic              cmd_bit_o,
    output logic              busy_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_vld_o,
    output logic              done_o,
    output logic              err_o
);
    localparam int CNTW = $clog2(XFER_LEN + 1);
    localparam logic [3:0] ACK_SLOT = 4'(BYTE_W);

    typedef struct packed {
        cstate_e           st;
        logic              pend;
        logic [BYTE_W-1:0] tx;
        logic [3:0]        idx;
        logic [BYTE_W-1:0] sh;
        logic [CNTW-1:0]   cnt;
        logic [BYTE_W-1:0] ra;
        logic              err;
        logic              done;
        logic              vld;
        logic [BYTE_W-1:0] dout;
        logic              issue;
        pcmd_e             cmd;
        logic              cbit;
    } ctl_t;

    ctl_t d, q;
    logic last;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.vld   = 1'b0;
        d.issue = 1'b0;
        last    = (q.cnt == CNTW'(XFER_LEN - 1));
        if (q.st == CS_IDLE) begin
            if (go_i) begin
                d.st   = CS_START;
                d.ra   = reg_addr_i;
                d.err  = 1'b0;
                d.pend = 1'b0;
                d.idx  = 4'd0;
                d.cnt  = '0;
            end
        end else if (!q.pend) begin
            d.pend  = 1'b1;
            d.issue = 1'b1;
            d.cbit  = 1'b0;
            case (q.st)
                CS_START:  d.cmd = PC_START;
                CS_RSTART: d.cmd = PC_RSTART;
                CS_STOP:   d.cmd = PC_STOP;
                CS_READ: begin
                    if (q.idx == ACK_SLOT) begin
                        d.cmd  = PC_WRITE;
                        d.cbit = last;
                    end else begin
                        d.cmd = PC_READ;
                    end
                end
                default: begin
                    if (q.idx == ACK_SLOT) begin
                        d.cmd = PC_READ;
                    end else begin
                        d.cmd  = PC_WRITE;
                        d.cbit = q.tx[BYTE_W-1];
                    end
                end
            endcase
        end else if (phy_done_i) begin
            d.pend = 1'b0;
            case (q.st)
                CS_START: begin
                    d.st  = CS_DEVW;
                    d.tx  = {DEV_ADDR, 1'b0};
                    d.idx = 4'd0;
                end
                CS_RSTART: begin
                    d.st  = CS_DEVR;
                    d.tx  = {DEV_ADDR, 1'b1};
                    d.idx = 4'd0;
                end
                CS_STOP: begin
                    d.st   = CS_IDLE;
                    d.done = 1'b1;
                end
                CS_READ: begin
                    if (q.idx != ACK_SLOT) begin
                        d.sh  = {q.sh[BYTE_W-2:0], phy_rx_i};
                        d.idx = q.idx + 4'd1;
                        if (q.idx == ACK_SLOT - 4'd1) begin
                            d.dout = {q.sh[BYTE_W-2:0], phy_rx_i};
                            d.vld  = 1'b1;
                        end
                    end else if (last) begin
                        d.st = CS_STOP;
                    end else begin
                        d.cnt = q.cnt + CNTW'(1);
                        d.idx = 4'd0;
                    end
                end
                default: begin
                    if (q.idx != ACK_SLOT) begin
                        d.tx  = {q.tx[BYTE_W-2:0], 1'b0};
                        d.idx = q.idx + 4'd1;
                    end else if (phy_rx_i) begin
                        d.err = 1'b1;
                        d.st  = CS_STOP;
                    end else begin
                        d.idx = 4'd0;
                        case (q.st)
                            CS_DEVW: begin
                                d.st = CS_REG;
                                d.tx = q.ra;
                            end
                            CS_REG:  d.st = CS_RSTART;
                            default: begin
                                d.st  = CS_READ;
                                d.cnt = '0;
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: CS_IDLE, pend: 1'b0, tx: '0, idx: 4'd0, sh: '0, cnt: '0,
                   ra: '0, err: 1'b0, done: 1'b0, vld: 1'b0, dout: '0,
                   issue: 1'b0, cmd: PC_STOP, cbit: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign cmd_vld_o  = q.issue;
    assign cmd_o      = q.cmd;
    assign cmd_bit_o  = q.cbit;
    assign busy_o     = (q.st != CS_IDLE);
    assign byte_o     = q.dout;
    assign byte_vld_o = q.vld;
    assign done_o     = q.done;
    assign err_o      = q.err;
endmodule

// File: rtl/eeprom_seq_reader.sv
module eeprom_seq_reader
    import eeprom_rd_pkg::*;
#(
    parameter int         SCL_QDIV = 125,
    parameter int         XFER_LEN = 128,
    parameter logic [6:0] DEV_ADDR = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [BYTE_W-1:0] reg_addr_i,
    input  logic              sda_i,
    output logic              scl_o,
    output logic              sda_oe_o,
    output logic              busy_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_vld_o,
    output logic              done_o,
    output logic              err_o
);
    logic  tick;
    logic  cmd_vld;
    pcmd_e cmd;
    logic  cmd_bit;
    logic  phy_done;
    logic  phy_rx;
    logic  phy_cond;

    eeprom_rd_tick #(.QDIV(SCL_QDIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    eeprom_rd_phy u_phy (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .cmd_vld_i (cmd_vld),
        .cmd_i     (cmd),
        .bit_i     (cmd_bit),
        .sda_i     (sda_i),
        .done_o    (phy_done),
        .rx_o      (phy_rx),
        .scl_o     (scl_o),
        .sda_oe_o  (sda_oe_o),
        .cond_o    (phy_cond)
    );

    eeprom_rd_ctrl #(.XFER_LEN(XFER_LEN), .DEV_ADDR(DEV_ADDR)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (go_i),
        .reg_addr_i (reg_addr_i),
        .phy_done_i (phy_done),
        .phy_rx_i   (phy_rx),
        .cmd_vld_o  (cmd_vld),
        .cmd_o      (cmd),
        .cmd_bit_o  (cmd_bit),
        .busy_o     (busy_o),
        .byte_o     (byte_o),
        .byte_vld_o (byte_vld_o),
        .done_o     (done_o),
        .err_o      (err_o)
    );
endmodule

// File: rtl/eeprom_seq_reader_chk.sv
module eeprom_seq_reader_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_o,
    input logic sda_oe_o,
    input logic busy_o,
    input logic byte_vld_o,
    input logic done_o,
    input logic err_o,
    input logic cond_i
);
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (scl_o && !sda_oe_o));

    a_r5_strobe_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |-> busy_o);

    a_r8_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !byte_vld_o);

    a_r9_sda_quiet_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && $past(scl_o) && (sda_oe_o != $past(sda_oe_o))) |-> cond_i);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
endmodule

bind eeprom_seq_reader eeprom_seq_reader_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_o      (scl_o),
    .sda_oe_o   (sda_oe_o),
    .busy_o     (busy_o),
    .byte_vld_o (byte_vld_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .cond_i     (phy_cond)
);

// File: tb/eeprom_seq_reader_tb.sv
`timescale 1ns/1ps
module eeprom_seq_reader_tb;
    localparam int LEN = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic       scl, sda_oe, busy, vld, done, err;
    logic [7:0] dbyte;

    logic s_oe = 1'b0;
    wire  sda_line = ~(sda_oe | s_oe);

    always #2 clk = ~clk;

    eeprom_seq_reader #(.SCL_QDIV(2), .XFER_LEN(LEN)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (go),
        .reg_addr_i (reg_addr),
        .sda_i      (sda_line),
        .scl_o      (scl),
        .sda_oe_o   (sda_oe),
        .busy_o     (busy),
        .byte_o     (dbyte),
        .byte_vld_o (vld),
        .done_o     (done),
        .err_o      (err)
    );

    int nchk = 0;
    int nerr = 0;
    bit over = 0;

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_val(input logic [7:0] a, input logic [7:0] s);
        logic [7:0] t;
        t = a * 8'd29;
        return t ^ s;
    endfunction

    // Behavioural EEPROM slave
    int         s_mode = 0;   // 0 idle, 1 device byte, 2 word address, 3 sending, 4 wait restart
    int         s_bc = 0;
    bit         s_skip = 0;
    bit         s_acked = 0;
    logic       s_mack = 1'b1;
    logic [7:0] s_sh = 8'h00, s_data = 8'h00, s_ptr = 8'h00;
    logic [7:0] seed = 8'h00;
    int         nack_sel = 0;
    int         starts = 0, stops = 0, edge_hi = 0, mack0 = 0, mack1 = 0;
    bit         rs_clean = 0;
    logic [7:0] cap_devw = 8'h00, cap_reg = 8'h00, cap_devr = 8'h00;

    always @(sda_line) if (scl === 1'b1) edge_hi++;

    always @(negedge sda_line) begin
        if (scl === 1'b1) begin
            if (starts == 1) rs_clean = (stops == 0);
            starts++;
            s_mode = 1; s_bc = 0; s_oe = 1'b0; s_skip = 1;
        end
    end

    always @(posedge sda_line) begin
        if (scl === 1'b1) begin
            stops++;
            s_mode = 0; s_oe = 1'b0;
        end
    end

    always @(posedge scl) begin
        if ((s_mode == 1 || s_mode == 2) && s_bc < 8) s_sh = {s_sh[6:0], sda_line};
        else if (s_mode == 3 && s_bc == 8) s_mack = sda_line;
    end

    always @(negedge scl) begin
        if (s_skip) begin
            s_skip = 0;
        end else if (s_mode >= 1 && s_mode <= 3) begin
            if (s_bc < 7) begin
                s_bc++;
                if (s_mode == 3) s_oe = ~s_data[7 - s_bc];
            end else if (s_bc == 7) begin
                s_bc = 8;
                if (s_mode == 1) begin
                    if (s_sh[0]) cap_devr = s_sh; else cap_devw = s_sh;
                    s_acked = !((!s_sh[0] && nack_sel == 1) || (s_sh[0] && nack_sel == 3));
                    s_oe = s_acked;
                end else if (s_mode == 2) begin
                    cap_reg = s_sh;
                    s_acked = (nack_sel != 2);
                    s_oe = s_acked;
                end else begin
                    s_oe = 1'b0;
                end
            end else begin
                s_bc = 0;
                if (s_mode == 1) begin
                    if (!s_acked) begin
                        s_mode = 0; s_oe = 1'b0;
                    end else if (s_sh[0]) begin
                        s_mode = 3; s_data = mem_val(s_ptr, seed); s_oe = ~s_data[7];
                    end else begin
                        s_mode = 2; s_oe = 1'b0;
                    end
                end else if (s_mode == 2) begin
                    s_ptr = s_sh; s_oe = 1'b0;
                    s_mode = s_acked ? 4 : 0;
                end else begin
                    if (s_mack == 1'b0) begin
                        mack0++; s_ptr = s_ptr + 8'd1;
                        s_data = mem_val(s_ptr, seed); s_oe = ~s_data[7];
                    end else begin
                        mack1++; s_mode = 0; s_oe = 1'b0;
                    end
                end
            end
        end
    end

    // Output monitor
    logic [7:0] rx_buf [0:255];
    int rx_n = 0;
    always @(negedge clk) begin
        if (vld) begin
            if (rx_n < 256) rx_buf[rx_n] = dbyte;
            rx_n++;
        end
    end

    task automatic run_xfer(input logic [7:0] ra, input int sel, input bit poke);
        int n;
        int mism;
        bit seen;
        starts = 0; stops = 0; edge_hi = 0; mack0 = 0; mack1 = 0; rs_clean = 0;
        cap_devw = 8'h00; cap_reg = 8'h00; cap_devr = 8'h00;
        rx_n = 0; nack_sel = sel; seed = 8'($urandom);
        @(negedge clk); reg_addr = ra; go = 1'b1;
        @(negedge clk); go = 1'b0;
        if (poke) begin
            repeat (300) @(negedge clk);
            reg_addr = ~ra; go = 1'b1;
            @(negedge clk); go = 1'b0;
        end
        n = 0;
        while (!done && n < 30000) begin @(negedge clk); n++; end
        seen = done;
        chk("R10 done pulse seen", seen, int'(seen), 1);
        chk("R10 busy low with done", !busy, int'(busy), 0);
        @(negedge clk);
        chk("R10 done lasts one cycle", !done, int'(done), 0);
        chk("R9 sda edges while scl high", edge_hi == ((sel == 0 || sel == 3) ? 3 : 2),
            edge_hi, (sel == 0 || sel == 3) ? 3 : 2);
        chk("R2 write address byte", cap_devw == 8'hA0, cap_devw, 8'hA0);
        chk("R6 single stop", stops == 1, stops, 1);
        if (sel == 0) begin
            mism = 0;
            for (int i = 0; i < rx_n && i < 256; i++)
                if (rx_buf[i] != mem_val(8'(ra + i), seed)) mism++;
            chk("R3 word address byte", cap_reg == ra, cap_reg, ra);
            chk("R4 repeated start without stop", rs_clean && starts == 2, starts, 2);
            chk("R4 read address byte", cap_devr == 8'hA1, cap_devr, 8'hA1);
            chk("R7 byte count", rx_n == LEN, rx_n, LEN);
            chk("R5 data mismatches", mism == 0, mism, 0);
            chk("R6 master acks", mack0 == LEN - 1, mack0, LEN - 1);
            chk("R6 final nack", mack1 == 1, mack1, 1);
            chk("R8 no error flag", !err, int'(err), 0);
        end else begin
            chk("R8 error flag", err, int'(err), 1);
            chk("R8 no data bytes", rx_n == 0, rx_n, 0);
            chk("R8 starts before abort", starts == ((sel == 3) ? 2 : 1), starts, (sel == 3) ? 2 : 1);
            if (sel >= 2) chk("R3 word address byte", cap_reg == ra, cap_reg, ra);
        end
        if (poke) begin
            repeat (100) @(negedge clk);
            chk("R11 go during busy ignored", starts == 2 && !busy, starts, 2);
        end
    endtask

    initial begin
        int unsigned dummy;
        dummy = $urandom(32'd11);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 scl idle high", scl == 1'b1, int'(scl), 1);
        chk("R1 sda released", sda_oe == 1'b0, int'(sda_oe), 0);
        chk("R1 flags low", !busy && !vld && !done && !err, int'({busy, vld, done, err}), 0);
        run_xfer(8'h00, 0, 0);
        run_xfer(8'hF0, 0, 1);
        run_xfer(8'($urandom), 1, 0);
        run_xfer(8'($urandom), 2, 0);
        run_xfer(8'($urandom), 3, 0);
        chk("R8 error held until next go", err, int'(err), 1);
        run_xfer(8'($urandom), 0, 0);
        run_xfer(8'($urandom), 0, 0);
        if (!over) begin
            over = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!over) begin
            over = 1;
            nchk++; nerr++;
            $display("FAIL R10 watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule